// File: doc/BRIEF.md
# Lane-Masked Video Memory Port

This block is a byte-addressed video memory with two access paths. A small I/O register port programs eight mask bytes, one for each of eight byte lanes. The memory port serves 8-, 16- and 32-bit reads and writes. Every write is merged into the stored bytes under the mask byte of its lane, so a drawing engine or DMA channel can update selected bit planes of packed pixels without a separate read by software.

The mask bytes are not addressed directly. A 2-bit index register selects a pair of lanes. A write to the mask window loads that pair and, where it exists, the mirror pair four lanes higher. Reads from the memory are never masked.

Each memory write takes two cycles. The request is accepted and its mask lanes are captured. In the next cycle the old bytes are read and the merged bytes are written back, while ready is held low. Read data arrives one cycle after acceptance.

Top module: `vmask_mem_top`

## Requirements
- R1: After reset the index register reads 0 and all eight mask bytes are 0xFF.
- R2: An I/O write to offset 0x458 loads the index register from data bits [1:0]. A 16-bit read of 0x458 returns the index zero-extended. A byte read returns 0xFF in the upper byte and the index in the lower byte.
- R3: A byte write to 0x45A stores data[7:0] in lane 2*idx, and a byte write to 0x45B stores it in lane 2*idx+1. Each also stores the same byte in the lane four above, but only where that lane is below 8, so idx 2 and 3 have no mirror.
- R4: A 16-bit write to 0x45A stores the low byte as a byte write to 0x45A would and the high byte as a byte write to 0x45B would. A 16-bit read of 0x45A returns {lane 2*idx+1, lane 2*idx}. Byte reads of 0x45A and 0x45B return {0xFF, lane 2*idx} and {0xFF, lane 2*idx+1}.
- R5: Each byte written to memory becomes (old & ~mask) | (new & mask), where mask is the mask byte of that byte's lane.
- R6: A byte write uses lane addr[1:0]. An aligned 32-bit write uses lanes 0..3 in byte order. A 16-bit write and an unaligned 32-bit write use lane byte_addr[2:0] for each of their bytes.
- R7: Memory reads return the stored bytes unmasked and little-endian. Size encodes 0 = byte, 1 = 16-bit, 2 or 3 = 32-bit. Bytes above the access size read as zero.
- R8: A multi-byte access touches consecutive byte addresses modulo MEM_BYTES. An unaligned access therefore crosses word boundaries and wraps past the top of the array.
- R9: I/O reads of any offset other than 0x458, 0x45A and 0x45B, including the cache-control offset 0x5EE, return 0xFFFF. A 16-bit read of 0x45B also returns 0xFFFF. I/O writes to those offsets change no state.
- R10: When a write is accepted, ready is low in the following cycle and high again in the cycle after. When a read is accepted, read valid is high in the following cycle with the data.
- R11: A write uses the mask bytes as they stood before the edge on which it is accepted. An I/O mask write on that same edge applies only to later writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_we_i | input | 1 | I/O write strobe for one cycle |
| io_wide_i | input | 1 | I/O access is 16-bit (else byte) |
| io_addr_i | input | 16 | I/O offset |
| io_wdata_i | input | 16 | I/O write data |
| io_rdata_o | output | 16 | I/O read data, combinational |
| mem_valid_i | input | 1 | Memory request valid |
| mem_ready_o | output | 1 | Memory port can accept |
| mem_we_i | input | 1 | Request is a write |
| mem_size_i | input | 2 | 0 byte, 1 16-bit, 2/3 32-bit |
| mem_addr_i | input | ADDR_W | Byte address |
| mem_wdata_i | input | 32 | Write data, little-endian |
| mem_rdata_o | output | 32 | Read data |
| mem_rvalid_o | output | 1 | Read data valid |

## Verification
An I/O mask write and the acceptance of a memory write can fall on the same clock edge. The bench provokes this by driving both ports in one cycle: it clears lane 0 over the I/O port while a byte write of 0xFF to a zeroed location is accepted. It then reads that byte back and expects 0xFF, because the old mask applies. A second write under the new zero mask must leave the byte unchanged.

// File: rtl/vmask_pkg.sv
package vmask_pkg;
  localparam int BANKS = 4;
  localparam int MASK_LANES = 8;

  localparam logic [15:0] IO_IDX   = 16'h0458;
  localparam logic [15:0] IO_MLO   = 16'h045A;
  localparam logic [15:0] IO_MHI   = 16'h045B;
  localparam logic [15:0] IO_CACHE = 16'h05EE; // decoded as unmapped

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WALT = 2'd3
  } size_e;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_MERGE = 1'b1
  } state_e;

  function automatic logic [2:0] size_bytes(logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/vmask_io_regs.sv
module vmask_io_regs
  import vmask_pkg::*;
(
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              io_we_i,
  input  logic                              io_wide_i,
  input  logic [15:0]                       io_addr_i,
  input  logic [15:0]                       io_wdata_i,
  output logic [15:0]                       io_rdata_o,
  output logic [MASK_LANES-1:0][7:0]        mask_o
);
  logic [1:0]                       idx_q;
  logic [MASK_LANES-1:0][7:0]       mask_q;
  logic [3:0]                       lo;
  logic [2:0]                       lo3, hi3;

  assign lo  = {1'b0, idx_q, 1'b0};
  assign lo3 = {idx_q, 1'b0};
  assign hi3 = {idx_q, 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      mask_q <= {MASK_LANES{8'hFF}};
    end else if (io_we_i) begin
      case (io_addr_i)
        IO_IDX: idx_q <= io_wdata_i[1:0];
        IO_MLO: begin
          for (int l = 0; l < MASK_LANES; l++) begin
            // mirror lane lo+4 exists only below MASK_LANES
            if (4'(l) == lo || 4'(l) == lo + 4'd4)
              mask_q[l] <= io_wdata_i[7:0];
            if (io_wide_i && (4'(l) == lo + 4'd1 || 4'(l) == lo + 4'd5))
              mask_q[l] <= io_wdata_i[15:8];
          end
        end
        IO_MHI: begin
          if (!io_wide_i) begin
            for (int l = 0; l < MASK_LANES; l++) begin
              if (4'(l) == lo + 4'd1 || 4'(l) == lo + 4'd5)
                mask_q[l] <= io_wdata_i[7:0];
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    io_rdata_o = 16'hFFFF;
    case (io_addr_i)
      IO_IDX: io_rdata_o = io_wide_i ? {14'd0, idx_q} : {8'hFF, 6'd0, idx_q};
      IO_MLO: io_rdata_o = io_wide_i ? {mask_q[hi3], mask_q[lo3]} : {8'hFF, mask_q[lo3]};
      IO_MHI: if (!io_wide_i) io_rdata_o = {8'hFF, mask_q[hi3]};
      default: ;
    endcase
  end

  assign mask_o = mask_q;

  p_idx_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_we_i && io_addr_i == IO_IDX) |=> idx_q == $past(io_wdata_i[1:0]));

  p_mirror_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_we_i && !io_wide_i && io_addr_i == IO_MLO && idx_q == 2'd0)
      |=> (mask_q[0] == $past(io_wdata_i[7:0])) && (mask_q[4] == mask_q[0]));

  p_unmapped_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_we_i && io_addr_i != IO_IDX && io_addr_i != IO_MLO && io_addr_i != IO_MHI)
      |=> $stable(mask_q) && $stable(idx_q));
endmodule

// File: rtl/vmask_lane_map.sv
module vmask_lane_map
  import vmask_pkg::*;
#(
  parameter int MA    = 10,
  parameter int ROW_W = MA - 2
) (
  input  logic [MA-1:0]                    addr_i,
  input  logic [1:0]                       size_i,
  input  logic [31:0]                      wdata_i,
  input  logic [MASK_LANES-1:0][7:0]       mask_i,
  input  logic [BANKS-1:0][7:0]            bank_rd_i,
  output logic [BANKS-1:0][ROW_W-1:0]      row_o,
  output logic [BANKS-1:0]                 en_o,
  output logic [BANKS-1:0][7:0]            data_o,
  output logic [BANKS-1:0][7:0]            lmask_o,
  output logic [31:0]                      rdata_o
);
  logic [2:0] nb;
  logic       word_aligned;
  logic       direct_lane;

  assign nb           = size_bytes(size_i);
  assign word_aligned = size_i[1] && (addr_i[1:0] == 2'b00);
  assign direct_lane  = (size_i == SZ_BYTE) || word_aligned;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    localparam logic [1:0] BK = 2'(b);
    logic [1:0]    k;     // byte position within the access served by bank b
    logic [MA-1:0] baddr;
    logic [2:0]    lane;

    assign k     = BK - addr_i[1:0];
    assign baddr = addr_i + MA'(k);
    assign lane  = direct_lane ? {1'b0, baddr[1:0]} : baddr[2:0];

    assign row_o[b]   = baddr[MA-1:2];
    assign en_o[b]    = {1'b0, k} < nb;
    assign data_o[b]  = wdata_i[{k, 3'b000} +: 8];
    assign lmask_o[b] = mask_i[lane];
  end

  for (genvar k = 0; k < BANKS; k++) begin : g_rd
    logic [1:0] src;
    assign src = addr_i[1:0] + 2'(k);
    assign rdata_o[8*k +: 8] = (3'(k) < nb) ? bank_rd_i[src] : 8'h00;
  end
endmodule

// File: rtl/vmask_bank.sv
module vmask_bank #(
  parameter int ROWS  = 256,
  parameter int ROW_W = $clog2(ROWS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ROW_W-1:0] row_i,
  input  logic             we_i,
  input  logic [7:0]       wdata_i,
  input  logic [7:0]       wmask_i,
  output logic [7:0]       rdata_o
);
  logic [7:0] mem_q [ROWS];

  assign rdata_o = mem_q[row_i];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[row_i] <= (rdata_o & ~wmask_i) | (wdata_i & wmask_i);
  end

  p_keep_unmasked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ((mem_q[$past(row_i)] ^ $past(rdata_o)) & ~$past(wmask_i)) == 8'h00);

  p_take_masked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ((mem_q[$past(row_i)] ^ $past(wdata_i)) & $past(wmask_i)) == 8'h00);
endmodule

// File: rtl/vmask_mem_top.sv
module vmask_mem_top
  import vmask_pkg::*;
#(
  parameter int MEM_BYTES = 1024,
  parameter int ADDR_W    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              io_we_i,
  input  logic              io_wide_i,
  input  logic [15:0]       io_addr_i,
  input  logic [15:0]       io_wdata_i,
  output logic [15:0]       io_rdata_o,
  input  logic              mem_valid_i,
  output logic              mem_ready_o,
  input  logic              mem_we_i,
  input  logic [1:0]        mem_size_i,
  input  logic [ADDR_W-1:0] mem_addr_i,
  input  logic [31:0]       mem_wdata_i,
  output logic [31:0]       mem_rdata_o,
  output logic              mem_rvalid_o
);
  localparam int MA    = $clog2(MEM_BYTES);
  localparam int ROWS  = MEM_BYTES / BANKS;
  localparam int ROW_W = MA - 2;

  logic [MASK_LANES-1:0][7:0] mask;
  logic [BANKS-1:0][ROW_W-1:0] map_row, q_row, bank_row;
  logic [BANKS-1:0]            map_en, q_en;
  logic [BANKS-1:0][7:0]       map_data, q_data, map_lmask, q_lmask, bank_rd;
  logic [31:0]                 map_rdata, rdata_q;
  logic                        rvalid_q;
  state_e                      state_q;
  logic                        accept;
  logic                        unused_addr_hi;

  assign unused_addr_hi = ^mem_addr_i[ADDR_W-1:MA];

  vmask_io_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .io_we_i    (io_we_i),
    .io_wide_i  (io_wide_i),
    .io_addr_i  (io_addr_i),
    .io_wdata_i (io_wdata_i),
    .io_rdata_o (io_rdata_o),
    .mask_o     (mask)
  );

  vmask_lane_map #(.MA(MA), .ROW_W(ROW_W)) u_map (
    .addr_i    (mem_addr_i[MA-1:0]),
    .size_i    (mem_size_i),
    .wdata_i   (mem_wdata_i),
    .mask_i    (mask),
    .bank_rd_i (bank_rd),
    .row_o     (map_row),
    .en_o      (map_en),
    .data_o    (map_data),
    .lmask_o   (map_lmask),
    .rdata_o   (map_rdata)
  );

  assign mem_ready_o = (state_q == ST_IDLE);
  assign accept      = mem_valid_i && mem_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      q_row    <= '0;
      q_en     <= '0;
      q_data   <= '0;
      q_lmask  <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= accept && !mem_we_i;
      if (accept && !mem_we_i) rdata_q <= map_rdata;
      case (state_q)
        ST_IDLE: if (accept && mem_we_i) begin
          // mask lanes captured here: later I/O writes do not affect this request
          q_row   <= map_row;
          q_en    <= map_en;
          q_data  <= map_data;
          q_lmask <= map_lmask;
          state_q <= ST_MERGE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    assign bank_row[b] = (state_q == ST_MERGE) ? q_row[b] : map_row[b];

    vmask_bank #(.ROWS(ROWS), .ROW_W(ROW_W)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .row_i   (bank_row[b]),
      .we_i    ((state_q == ST_MERGE) && q_en[b]),
      .wdata_i (q_data[b]),
      .wmask_i (q_lmask[b]),
      .rdata_o (bank_rd[b])
    );
  end

  assign mem_rdata_o  = rdata_q;
  assign mem_rvalid_o = rvalid_q;

  p_write_stall_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_i && mem_ready_o && mem_we_i) |=> !mem_ready_o && !mem_rvalid_o);

  p_read_latency_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_i && mem_ready_o && !mem_we_i) |=> mem_rvalid_o);

  p_stall_one_cycle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_ready_o |=> mem_ready_o);

  p_rvalid_source_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rvalid_o |-> $past(mem_valid_i && !mem_we_i));
endmodule

// File: tb/vmask_mem_top_bench.sv
`timescale 1ns/1ps
module vmask_mem_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_we = 1'b0, io_wide = 1'b0;
  logic [15:0] io_addr = '0, io_wdata = '0, io_rdata;
  logic        mem_valid = 1'b0, mem_we = 1'b0, mem_ready, mem_rvalid;
  logic [1:0]  mem_size = '0;
  logic [15:0] mem_addr = '0;
  logic [31:0] mem_wdata = '0, mem_rdata;
  int          n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  vmask_mem_top u_vmask_mem_top (
    .clk_i(clk), .rst_ni(rst_n),
    .io_we_i(io_we), .io_wide_i(io_wide), .io_addr_i(io_addr),
    .io_wdata_i(io_wdata), .io_rdata_o(io_rdata),
    .mem_valid_i(mem_valid), .mem_ready_o(mem_ready), .mem_we_i(mem_we),
    .mem_size_i(mem_size), .mem_addr_i(mem_addr), .mem_wdata_i(mem_wdata),
    .mem_rdata_o(mem_rdata), .mem_rvalid_o(mem_rvalid)
  );

  typedef struct packed {
    logic        wr;
    logic [1:0]  sz;
    logic [15:0] addr;
    logic [31:0] data; // write data or expected read data
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 2'd2, 16'h0100, 32'h00000000},
    '{1'b1, 2'd2, 16'h0104, 32'h00000000},
    '{1'b1, 2'd2, 16'h0200, 32'h00000000},
    '{1'b1, 2'd2, 16'h0014, 32'h00000077},
    '{1'b1, 2'd2, 16'h0010, 32'h11223344},
    '{1'b0, 2'd2, 16'h0010, 32'h11223344},
    '{1'b0, 2'd0, 16'h0011, 32'h00000033},
    '{1'b0, 2'd1, 16'h0012, 32'h00001122},
    '{1'b1, 2'd1, 16'h0011, 32'h0000AABB},
    '{1'b0, 2'd2, 16'h0010, 32'h11AABB44},
    '{1'b1, 2'd0, 16'h0013, 32'h0000005A},
    '{1'b0, 2'd3, 16'h0011, 32'h775AAABB},
    '{1'b0, 2'd1, 16'h0013, 32'h0000775A}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic io_wr(input logic wide, input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    io_we = 1'b1; io_wide = wide; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_we = 1'b0;
  endtask

  task automatic io_rd(input logic wide, input logic [15:0] a, output logic [15:0] d);
    @(negedge clk);
    io_wide = wide; io_addr = a;
    #1 d = io_rdata;
  endtask

  task automatic mem_wr(input logic [1:0] sz, input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    mem_valid = 1'b1; mem_we = 1'b1; mem_size = sz; mem_addr = a; mem_wdata = d;
    @(negedge clk);
    mem_valid = 1'b0; mem_we = 1'b0;
    chk("R10 ready low in merge cycle", 32'(mem_ready), 32'd0);
    @(negedge clk);
    chk("R10 ready back after merge", 32'(mem_ready), 32'd1);
  endtask

  task automatic mem_rd(input logic [1:0] sz, input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    mem_valid = 1'b1; mem_we = 1'b0; mem_size = sz; mem_addr = a;
    @(negedge clk);
    mem_valid = 1'b0;
    chk("R10 rvalid one cycle after read", 32'(mem_rvalid), 32'd1);
    d = mem_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] r16;
    logic [31:0] r32;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    io_rd(1'b1, 16'h0458, r16); chk("R1 index after reset", 32'(r16), 32'h0000);
    io_rd(1'b1, 16'h045A, r16); chk("R1 lanes 0/1 after reset", 32'(r16), 32'hFFFF);
    chk("R1 ready after reset", 32'(mem_ready), 32'd1);
    chk("R1 rvalid after reset", 32'(mem_rvalid), 32'd0);

    // R7 R8 table walk with all masks open
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i].wr) mem_wr(VEC[i].sz, VEC[i].addr, VEC[i].data);
      else begin
        mem_rd(VEC[i].sz, VEC[i].addr, r32);
        chk($sformatf("R7 table entry %0d", i), r32, VEC[i].data);
      end
    end

    // R2 index register, only bits [1:0] kept
    io_wr(1'b1, 16'h0458, 16'h00FE);
    io_rd(1'b1, 16'h0458, r16); chk("R2 index wide read", 32'(r16), 32'h0002);
    io_rd(1'b0, 16'h0458, r16); chk("R2 index byte read", 32'(r16), 32'hFF02);

    // R3 R4 program lanes: 0=0F 1=F0 2=C3 3=3C, 4..7=FF
    io_wr(1'b0, 16'h0458, 16'h0000);
    io_wr(1'b0, 16'h045A, 16'h000F);
    io_wr(1'b0, 16'h045B, 16'h00F0);
    io_wr(1'b1, 16'h0458, 16'h0001);
    io_wr(1'b1, 16'h045A, 16'h3CC3);
    io_wr(1'b1, 16'h0458, 16'h0002);
    io_wr(1'b1, 16'h045A, 16'hFFFF);
    io_wr(1'b1, 16'h0458, 16'h0003);
    io_wr(1'b1, 16'h045A, 16'hFFFF);
    io_rd(1'b1, 16'h045A, r16); chk("R3 idx3 lanes 6/7", 32'(r16), 32'hFFFF);
    io_wr(1'b1, 16'h0458, 16'h0001);
    io_rd(1'b1, 16'h045A, r16); chk("R4 wide read lanes 2/3", 32'(r16), 32'h3CC3);
    io_wr(1'b1, 16'h0458, 16'h0000);
    io_rd(1'b0, 16'h045B, r16); chk("R4 byte read lane 1", 32'(r16), 32'hFFF0);
    io_rd(1'b0, 16'h045A, r16); chk("R4 byte read lane 0", 32'(r16), 32'hFF0F);

    // R6 aligned word uses lanes 0..3
    mem_wr(2'd2, 16'h0104, 32'hFFFFFFFF);
    mem_rd(2'd2, 16'h0104, r32); chk("R6 aligned word lanes 0..3", r32, 32'h3CC3F00F);
    // R6 halfword at 0x106 uses lanes 6/7 (FF)
    mem_wr(2'd1, 16'h0106, 32'h0000FFFF);
    mem_rd(2'd2, 16'h0104, r32); chk("R6 halfword lanes 6/7", r32, 32'hFFFFF00F);
    // R6 byte at 0x105 uses lane 1 (F0), not lane 5
    mem_wr(2'd0, 16'h0105, 32'h000000FF);
    mem_rd(2'd2, 16'h0104, r32); chk("R6 byte lane from addr[1:0]", r32, 32'hFFFFF00F);
    // R8 unaligned word: lanes 1,2,3,4
    mem_wr(2'd2, 16'h0101, 32'hFFFFFFFF);
    mem_rd(2'd2, 16'h0100, r32); chk("R8 unaligned word lanes 1..3", r32, 32'h3CC3F000);
    mem_rd(2'd0, 16'h0104, r32); chk("R8 unaligned word lane 4", r32, 32'h000000FF);
    // R5 merge with partial data
    mem_wr(2'd0, 16'h0100, 32'h000000A5);
    mem_rd(2'd0, 16'h0100, r32); chk("R5 merge under mask 0F", r32, 32'h00000005);

    // restore open masks
    io_wr(1'b1, 16'h045A, 16'hFFFF);
    io_wr(1'b1, 16'h0458, 16'h0001);
    io_wr(1'b1, 16'h045A, 16'hFFFF);

    // R8 wrap past top of array
    mem_wr(2'd2, 16'h03FE, 32'h44332211);
    mem_rd(2'd1, 16'h0000, r32); chk("R8 wrap low half", r32, 32'h00004433);
    mem_rd(2'd1, 16'h03FE, r32); chk("R8 wrap top half", r32, 32'h00002211);

    // R9 unmapped offsets
    io_wr(1'b1, 16'h05EE, 16'h0000);
    io_wr(1'b1, 16'h0400, 16'h0000);
    io_rd(1'b1, 16'h05EE, r16); chk("R9 cache offset read", 32'(r16), 32'hFFFF);
    io_rd(1'b0, 16'h0400, r16); chk("R9 unmapped byte read", 32'(r16), 32'hFFFF);
    io_rd(1'b1, 16'h045B, r16); chk("R9 wide read of 0x45B", 32'(r16), 32'hFFFF);
    io_rd(1'b1, 16'h0458, r16); chk("R9 index unchanged", 32'(r16), 32'h0001);
    io_rd(1'b1, 16'h045A, r16); chk("R9 mask unchanged", 32'(r16), 32'hFFFF);

    // R11 mask write on the same edge as write acceptance
    io_wr(1'b1, 16'h0458, 16'h0000);
    @(negedge clk);
    io_we = 1'b1; io_wide = 1'b0; io_addr = 16'h045A; io_wdata = 16'h0000;
    mem_valid = 1'b1; mem_we = 1'b1; mem_size = 2'd0; mem_addr = 16'h0200; mem_wdata = 32'hFF;
    @(negedge clk);
    io_we = 1'b0; mem_valid = 1'b0; mem_we = 1'b0;
    @(negedge clk);
    mem_rd(2'd0, 16'h0200, r32); chk("R11 old mask applied", r32, 32'h000000FF);
    mem_wr(2'd0, 16'h0200, 32'h00000000);
    mem_rd(2'd0, 16'h0200, r32); chk("R11 new mask applies later", r32, 32'h000000FF);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule